// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers the eight interrupt sources of a two-channel serial controller into one status register and drives a single active-low interrupt line through a programmable mask. The sources are four level conditions, which are the receive and transmit fill-level conditions of each channel. There are also four sticky events: a break edge on each channel, a counter-ready pulse, and a change of state on the general-purpose input pins of either port.

Each sticky bit has its own way of being cleared. The pin-change bit clears when the CPU reads the port-change register, signalled by a strobe. Each break bit clears on its own channel's reset command. The counter bit clears on a stop-counter command. Level bits simply track their inputs. A small register interface writes the mask and the pin-change enables, and reads back the status, the mask and the enables. The mask never alters what a status read returns.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset, the status reads 0x00, the mask reads 0x00, the pin enables read 0, and `irqN` is high.
- R2: Status bit positions are: 7 pin change, 6 break change B, 5 Rx B, 4 Tx B, 3 counter ready, 2 break change A, 1 Rx A, 0 Tx A. Status is read with `regSel`=0.
- R3: `irqN` is low exactly when some status bit and the matching mask bit are both 1. The mask is written and read at `regSel`=1.
- R4: A status read returns the unmasked status for every mask value.
- R5: Status bits 0, 1, 4 and 5 equal the values that `txLvlA`, `rxLvlA`, `txLvlB` and `rxLvlB` held at the previous clock edge.
- R6: A pulse on `brkEdgeA` or `brkEdgeB` sets bit 2 or bit 6, respectively. The bit then holds until that channel's clear strobe (`clrBrkA` or `clrBrkB`). The other channel's clear strobe has no effect on it.
- R7: A `cntReady` pulse sets bit 3, which holds until a `stopCnt` strobe clears it.
- R8: A rising or falling edge on pin i of `pinA` or `pinB` sets bit 7 when enable bit i is 1. The edge has no effect when that bit is 0. A `rdPortChg` strobe clears bit 7. The enables are written and read at `regSel`=2, in bits 3:0, and bits 7:4 read 0.
- R9: When a set event and a clear strobe reach the same sticky bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxLvlA | input | 1 | Channel A receive level condition |
| txLvlA | input | 1 | Channel A transmit level condition |
| rxLvlB | input | 1 | Channel B receive level condition |
| txLvlB | input | 1 | Channel B transmit level condition |
| brkEdgeA | input | 1 | Channel A break start/end pulse |
| brkEdgeB | input | 1 | Channel B break start/end pulse |
| cntReady | input | 1 | Counter-ready pulse |
| pinA | input | 4 | Port A input pins (synchronous) |
| pinB | input | 4 | Port B input pins (synchronous) |
| rdPortChg | input | 1 | CPU read of the port-change register |
| clrBrkA | input | 1 | Reset break-change command, channel A |
| clrBrkB | input | 1 | Reset break-change command, channel B |
| stopCnt | input | 1 | Stop-counter command |
| regSel | input | 2 | Register select |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| irqN | output | 1 | Active-low interrupt |

## Verification
On every cycle, the assertions check four things. Level bits track their inputs one edge later. Sticky bits hold until their own clear strobe arrives. A set event always leaves its bit set. A low `irqN` always has an unmasked active source behind it. The bench's scenarios are the only place three other properties are shown. First, the mask has no effect on status reads, checked across all 256 mask values. Second, each pin-enable combination gates both edges of every pin. Third, a clear strobe aimed at one channel leaves the other channel's break bit in place.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W = 8;
  localparam int PIN_N  = 4;
  localparam int SEL_W  = 2;

  localparam int B_TXA = 0;
  localparam int B_RXA = 1;
  localparam int B_BRKA = 2;
  localparam int B_CNT = 3;
  localparam int B_TXB = 4;
  localparam int B_RXB = 5;
  localparam int B_BRKB = 6;
  localparam int B_PORT = 7;

  localparam logic [DATA_W-1:0] STICKY = 8'b1100_1100;

  localparam logic [SEL_W-1:0] SEL_STAT = 2'd0;
  localparam logic [SEL_W-1:0] SEL_MASK = 2'd1;
  localparam logic [SEL_W-1:0] SEL_PEN  = 2'd2;

  typedef struct packed {
    logic wrMask;
    logic wrPinEn;
    logic clrPort;
    logic clrBrkA;
    logic clrBrkB;
    logic clrCnt;
  } irqCmd_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic             regWr,
  input  logic [SEL_W-1:0] regSel,
  input  logic             rdPortChg,
  input  logic             clrBrkA,
  input  logic             clrBrkB,
  input  logic             stopCnt,
  output irqCmd_t          cmd
);
  always_comb begin
    cmd         = '0;
    cmd.wrMask  = regWr && (regSel == SEL_MASK);
    cmd.wrPinEn = regWr && (regSel == SEL_PEN);
    cmd.clrPort = rdPortChg;
    cmd.clrBrkA = clrBrkA;
    cmd.clrBrkB = clrBrkB;
    cmd.clrCnt  = stopCnt;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int PINS = PIN_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irqCmd_t          cmd,
  input  logic             rxLvlA,
  input  logic             txLvlA,
  input  logic             rxLvlB,
  input  logic             txLvlB,
  input  logic             brkEdgeA,
  input  logic             brkEdgeB,
  input  logic             cntReady,
  input  logic [PINS-1:0]  pinA,
  input  logic [PINS-1:0]  pinB,
  input  logic [SEL_W-1:0] regSel,
  input  logic [W-1:0]     regWdata,
  output logic [W-1:0]     regRdata,
  output logic [W-1:0]     statusQ,
  output logic [W-1:0]     maskQ,
  output logic             irqN
);
  logic [PINS-1:0] pinEnQ, pinAPrev, pinBPrev;
  logic [W-1:0]    setVec, clrVec, lvlVec;
  logic            portChg;

  assign portChg = |(((pinA ^ pinAPrev) | (pinB ^ pinBPrev)) & pinEnQ);

  always_comb begin
    setVec = '0;
    clrVec = '0;
    lvlVec = '0;
    setVec[B_PORT] = portChg;   clrVec[B_PORT] = cmd.clrPort;
    setVec[B_BRKB] = brkEdgeB;  clrVec[B_BRKB] = cmd.clrBrkB;
    setVec[B_CNT]  = cntReady;  clrVec[B_CNT]  = cmd.clrCnt;
    setVec[B_BRKA] = brkEdgeA;  clrVec[B_BRKA] = cmd.clrBrkA;
    lvlVec[B_RXB]  = rxLvlB;
    lvlVec[B_TXB]  = txLvlB;
    lvlVec[B_RXA]  = rxLvlA;
    lvlVec[B_TXA]  = txLvlA;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      always_ff @(posedge clk) begin
        if (!rst_n) statusQ[i] <= 1'b0;
        else        statusQ[i] <= setVec[i] | (statusQ[i] & ~clrVec[i]);
      end
    end else begin : g_level
      always_ff @(posedge clk) begin
        if (!rst_n) statusQ[i] <= 1'b0;
        else        statusQ[i] <= lvlVec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskQ    <= '0;
      pinEnQ   <= '0;
      pinAPrev <= '0;
      pinBPrev <= '0;
    end else begin
      if (cmd.wrMask)  maskQ  <= regWdata;
      if (cmd.wrPinEn) pinEnQ <= regWdata[PINS-1:0];
      pinAPrev <= pinA;
      pinBPrev <= pinB;
    end
  end

  always_comb begin
    case (regSel)
      SEL_STAT: regRdata = statusQ;
      SEL_MASK: regRdata = maskQ;
      SEL_PEN:  regRdata = {{(W-PINS){1'b0}}, pinEnQ};
      default:  regRdata = '0;
    endcase
  end

  assign irqN = ~|(statusQ & maskQ);
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxLvlA,
  input  logic        txLvlA,
  input  logic        rxLvlB,
  input  logic        txLvlB,
  input  logic        brkEdgeA,
  input  logic        brkEdgeB,
  input  logic        cntReady,
  input  logic [3:0]  pinA,
  input  logic [3:0]  pinB,
  input  logic        rdPortChg,
  input  logic        clrBrkA,
  input  logic        clrBrkB,
  input  logic        stopCnt,
  input  logic [1:0]  regSel,
  input  logic        regWr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  output logic        irqN
);
  irqCmd_t     cmd;
  logic [7:0]  statusQ, maskQ;

  irq_ctrl u_ctrl (
    .regWr(regWr), .regSel(regSel), .rdPortChg(rdPortChg),
    .clrBrkA(clrBrkA), .clrBrkB(clrBrkB), .stopCnt(stopCnt), .cmd(cmd)
  );

  irq_datapath #(.W(DATA_W), .PINS(PIN_N)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .rxLvlA(rxLvlA), .txLvlA(txLvlA), .rxLvlB(rxLvlB), .txLvlB(txLvlB),
    .brkEdgeA(brkEdgeA), .brkEdgeB(brkEdgeB), .cntReady(cntReady),
    .pinA(pinA), .pinB(pinB), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .statusQ(statusQ), .maskQ(maskQ), .irqN(irqN)
  );
endmodule

// File: rtl/irq_chk.sv
module irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] statusQ,
  input logic [7:0] maskQ,
  input logic       irqN,
  input logic       rxLvlA,
  input logic       txLvlB,
  input logic       brkEdgeA,
  input logic       clrBrkA,
  input logic       brkEdgeB,
  input logic       clrBrkB,
  input logic       cntReady,
  input logic       stopCnt,
  input logic       rdPortChg
);
  p_irq_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irqN |-> ((statusQ & maskQ) != 8'h00));

  p_rx_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (statusQ[1] == $past(rxLvlA)));

  p_tx_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (statusQ[4] == $past(txLvlB)));

  p_brka_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (statusQ[2] && !clrBrkA) |=> statusQ[2]);

  p_brkb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (statusQ[6] && !clrBrkB) |=> statusQ[6]);

  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stopCnt && !cntReady) |=> !statusQ[3]);

  p_port_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (statusQ[7] && !rdPortChg) |=> statusQ[7]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brkEdgeA || brkEdgeB || cntReady) |=>
      ((statusQ[2] || !$past(brkEdgeA)) && (statusQ[6] || !$past(brkEdgeB))
       && (statusQ[3] || !$past(cntReady))));
endmodule

bind irq_stat_unit irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .statusQ(statusQ), .maskQ(maskQ), .irqN(irqN),
  .rxLvlA(rxLvlA), .txLvlB(txLvlB), .brkEdgeA(brkEdgeA), .clrBrkA(clrBrkA),
  .brkEdgeB(brkEdgeB), .clrBrkB(clrBrkB), .cntReady(cntReady),
  .stopCnt(stopCnt), .rdPortChg(rdPortChg)
);

// File: tb/sim_irq_stat_unit.sv
module sim_irq_stat_unit;
  logic clk = 0, rst_n = 0;
  logic rxLvlA = 0, txLvlA = 0, rxLvlB = 0, txLvlB = 0;
  logic brkEdgeA = 0, brkEdgeB = 0, cntReady = 0;
  logic [3:0] pinA = 0, pinB = 0;
  logic rdPortChg = 0, clrBrkA = 0, clrBrkB = 0, stopCnt = 0;
  logic [1:0] regSel = 0;
  logic regWr = 0;
  logic [7:0] regWdata = 0;
  logic [7:0] regRdata;
  logic irqN;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_stat_unit u0 (.*);

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdReg(input logic [1:0] s, output logic [7:0] v);
    regSel = s; #1; v = regRdata;
  endtask

  task automatic wrReg(input logic [1:0] s, input logic [7:0] v);
    regSel = s; regWdata = v; regWr = 1; step(); regWr = 0;
  endtask

  task automatic clearAll();
    rxLvlA = 0; txLvlA = 0; rxLvlB = 0; txLvlB = 0;
    rdPortChg = 1; clrBrkA = 1; clrBrkB = 1; stopCnt = 1; step();
    rdPortChg = 0; clrBrkA = 0; clrBrkB = 0; stopCnt = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, exp;
    repeat (3) step();
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rdReg(0, v); chk("R1 status", v, 8'h00);
    rdReg(1, v); chk("R1 mask", v, 8'h00);
    rdReg(2, v); chk("R1 pinEn", v, 8'h00);
    chk("R1 irqN", {7'b0, irqN}, 8'h01);

    // R5/R2 level sweep
    for (int k = 0; k < 16; k++) begin
      {rxLvlB, txLvlB, rxLvlA, txLvlA} = 4'(k);
      step();
      exp = {2'b00, k[3], k[2], 2'b00, k[1], k[0]};
      rdReg(0, v); chk("R5 level bits", v, exp);
    end
    clearAll(); step();

    // R6 break bits
    brkEdgeA = 1; step(); brkEdgeA = 0;
    rdReg(0, v); chk("R6 brkA set bit2", v, 8'h04);
    clrBrkB = 1; step(); clrBrkB = 0;
    rdReg(0, v); chk("R6 brkA held over clrBrkB", v, 8'h04);
    clrBrkA = 1; step(); clrBrkA = 0;
    rdReg(0, v); chk("R6 brkA cleared", v, 8'h00);
    brkEdgeB = 1; step(); brkEdgeB = 0;
    rdReg(0, v); chk("R6 brkB set bit6", v, 8'h40);
    clrBrkA = 1; step(); clrBrkA = 0;
    rdReg(0, v); chk("R6 brkB held over clrBrkA", v, 8'h40);
    clrBrkB = 1; step(); clrBrkB = 0;
    rdReg(0, v); chk("R6 brkB cleared", v, 8'h00);

    // R7 counter
    cntReady = 1; step(); cntReady = 0;
    repeat (3) step();
    rdReg(0, v); chk("R7 cnt set/hold", v, 8'h08);
    stopCnt = 1; step(); stopCnt = 0;
    rdReg(0, v); chk("R7 cnt cleared", v, 8'h00);

    // R8 pin change sweep
    for (int en = 0; en < 16; en++) begin
      wrReg(2, 8'(en));
      rdReg(2, v); chk("R8 pinEn readback", v, 8'(en));
      for (int p = 0; p < 2; p++)
        for (int i = 0; i < 4; i++)
          for (int e = 0; e < 2; e++) begin
            if (p == 0) pinA[i] = ~pinA[i]; else pinB[i] = ~pinB[i];
            step();
            rdReg(0, v);
            chk("R8 pin change", v, {en[i], 7'b0});
            rdPortChg = 1; step(); rdPortChg = 0;
            rdReg(0, v); chk("R8 cleared by read", v, 8'h00);
          end
    end

    // R9 set wins
    brkEdgeA = 1; clrBrkA = 1; brkEdgeB = 1; clrBrkB = 1;
    cntReady = 1; stopCnt = 1; pinA[0] = ~pinA[0]; rdPortChg = 1;
    step();
    brkEdgeA = 0; clrBrkA = 0; brkEdgeB = 0; clrBrkB = 0;
    cntReady = 0; stopCnt = 0; rdPortChg = 0;
    rdReg(0, v); chk("R9 set beats clear", v, 8'hCC);

    // R3/R4 mask sweep with full and partial status
    for (int s = 0; s < 2; s++) begin
      clearAll();
      if (s == 0) begin
        rxLvlA = 1; txLvlA = 1; rxLvlB = 1; txLvlB = 1;
        brkEdgeA = 1; brkEdgeB = 1; cntReady = 1; pinA[1] = ~pinA[1];
        exp = 8'hFF;
      end else begin
        txLvlA = 1; rxLvlB = 1; brkEdgeB = 1;
        exp = 8'h61;
      end
      step();
      brkEdgeA = 0; brkEdgeB = 0; cntReady = 0;
      for (int m = 0; m < 256; m++) begin
        wrReg(1, 8'(m));
        rdReg(1, v); chk("R3 mask readback", v, 8'(m));
        rdReg(0, v); chk("R4 status unmasked", v, exp);
        chk("R3 irqN", {7'b0, irqN}, {7'b0, ((exp & 8'(m)) == 8'h00)});
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule